// File: doc/BRIEF.md
# Windowed Watchdog Timer

A 12-bit down-counting watchdog that must be serviced inside a window. Software configures it once after reset through a mode register. It then restarts the count by writing the restart bit of the control register. The restart is only legal once the count has dropped to or below a programmed delta. An early restart is treated as a fault, the same as letting the count run out.

A fault sets a sticky flag. The flags can be read, and a read of the status register clears them. A fault can raise a level interrupt, and it can also emit a one-cycle reset request. That request goes either to the processor alone or to the whole system. The count advances only on cycles where the tick-enable input is high. It can be frozen while the debug or idle status inputs are active, and a disable bit stops it entirely.

Register access uses a plain strobe bus with a 2-bit word address. Read data is combinational from the address.

Top module: `win_wdog`

## Requirements
- R1: After reset the mode register reads 0x0FFF2FFF (load and delta 0xFFF, reset-enable bit 13 set), the count register (address 3, bits 11:0) reads 0xFFF, the status register (address 2) reads 0, and irq_o, proc_rst_o and sys_rst_o are low.
- R2: Only the first write to the mode register (address 1) after reset takes effect. It stores wdata bits 29:0 and loads the count from bits 11:0. Every later write leaves both the register and the count unchanged.
- R3: On a cycle with tick_i high that is not halted or disabled, the count drops by one.
- R4: A tick at count 0 is an underflow. It sets status bit 0 and reloads the count from the load field (bits 11:0).
- R5: A write to the control register (address 0) with bit 0 set, while count is less than or equal to the delta field (bits 27:16), reloads the count from the load field.
- R6: Such a restart while count exceeds the delta is an error. It sets status bit 1 and does not reload the count; the tick still applies that cycle.
- R7: With mode bit 28 set, the count holds while dbg_i is high. With mode bit 29 set, it holds while idle_i is high. With the bit clear, the input has no effect.
- R8: With mode bit 15 set, the count never changes, restarts are ignored and no fault is raised.
- R9: A read strobe (re_i) at address 2 returns the flags and clears them at that edge. A fault in the same cycle still sets its flag.
- R10: irq_o is high exactly while mode bit 12 is set and at least one status flag is set.
- R11: Each fault with mode bit 13 set gives a one-cycle pulse in the cycle after the fault. The pulse appears on proc_rst_o when bit 14 is 1 and on sys_rst_o when bit 14 is 0. With bit 13 clear, neither output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (side effect on status) |
| addr_i | input | 2 | Word address: 0 control, 1 mode, 2 status, 3 count |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| tick_i | input | 1 | Count enable |
| dbg_i | input | 1 | Processor in debug state |
| idle_i | input | 1 | System in idle state |
| irq_o | output | 1 | Fault interrupt level |
| proc_rst_o | output | 1 | Processor reset request pulse |
| sys_rst_o | output | 1 | Full-system reset request pulse |

## Verification
The hardest situations to reach are the ones that need a particular configuration. The mode register accepts one write per reset, so disabled operation, halting and each reset-routing choice cannot be visited in a single run. The bench therefore cycles through many reset epochs, each with a freshly drawn configuration that uses short load and delta values. Within an epoch, restarts, status reads, ignored mode writes and halt inputs are scattered at random. This makes both early and in-window restarts occur, along with faults that coincide with clearing reads. Directed epochs pin the exact window boundary, a restart at count equal to the delta, and the underflow from zero.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_MODE  = 2'd1,
    A_STAT  = 2'd2,
    A_COUNT = 2'd3
  } reg_addr_e;

  // packed msb-first so it maps straight onto wdata[29:0]
  typedef struct packed {
    logic             idle_hlt;  // 29
    logic             dbg_hlt;   // 28
    logic [CNT_W-1:0] delta;     // 27:16
    logic             dis;       // 15
    logic             rproc;     // 14
    logic             rsten;     // 13
    logic             fien;      // 12
    logic [CNT_W-1:0] load;      // 11:0
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
  localparam mode_t MODE_RST = '{idle_hlt: 1'b0, dbg_hlt: 1'b0, delta: '1, dis: 1'b0,
                                 rproc: 1'b0, rsten: 1'b1, fien: 1'b0, load: '1};
endpackage

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
  import win_wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] wdata_i,
  output mode_t             mode_o,
  output logic              load_o
);
  logic written_q;

  assign load_o = wr_i & ~written_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MODE_RST;
      written_q <= 1'b0;
    end else if (load_o) begin
      mode_o    <= mode_t'(wdata_i);
      written_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import win_wdog_pkg::*;
#(
  parameter int unsigned N_HALT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_t             mode_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [N_HALT-1:0] halt_src_i,
  input  logic [N_HALT-1:0] halt_en_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              unf_o,
  output logic              err_o
);
  logic [N_HALT-1:0] halt_act;
  logic              run;
  logic [CNT_W-1:0]  cnt_d;

  for (genvar g = 0; g < N_HALT; g++) begin : g_halt
    assign halt_act[g] = halt_src_i[g] & halt_en_i[g];
  end

  assign run = tick_i & ~(|halt_act);

  always_comb begin
    cnt_d = cnt_o;
    unf_o = 1'b0;
    err_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (!mode_i.dis) begin
      if (restart_i && (cnt_o <= mode_i.delta)) begin
        cnt_d = mode_i.load;
      end else begin
        err_o = restart_i;
        if (run) begin
          if (cnt_o == '0) begin
            unf_o = 1'b1;
            cnt_d = mode_i.load;
          end else begin
            cnt_d = cnt_o - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= MODE_RST.load;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/wdog_fault.sv
module wdog_fault
  import win_wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_t      mode_i,
  input  logic       unf_i,
  input  logic       err_i,
  input  logic       clr_i,
  output logic [1:0] flags_o,
  output logic       irq_o,
  output logic       proc_rst_o,
  output logic       sys_rst_o
);
  logic fault;
  assign fault = unf_i | err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o    <= '0;
      proc_rst_o <= 1'b0;
      sys_rst_o  <= 1'b0;
    end else begin
      // a new fault wins over a clearing read
      flags_o[0] <= unf_i | (flags_o[0] & ~clr_i);
      flags_o[1] <= err_i | (flags_o[1] & ~clr_i);
      proc_rst_o <= fault & mode_i.rsten & mode_i.rproc;
      sys_rst_o  <= fault & mode_i.rsten & ~mode_i.rproc;
    end
  end

  assign irq_o = mode_i.fien & (|flags_o);
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              dbg_i,
  input  logic              idle_i,
  output logic              irq_o,
  output logic              proc_rst_o,
  output logic              sys_rst_o
);
  mode_t            mode_q;
  logic             mode_load;
  logic [CNT_W-1:0] cnt;
  logic             unf_evt, err_evt;
  logic [1:0]       flags;
  logic             restart, stat_clr;

  assign restart  = we_i & (addr_i == A_CTRL) & wdata_i[0];
  assign stat_clr = re_i & (addr_i == A_STAT);

  wdog_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i & (addr_i == A_MODE)),
    .wdata_i (wdata_i[MODE_W-1:0]),
    .mode_o  (mode_q),
    .load_o  (mode_load)
  );

  wdog_counter #(.N_HALT(2)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .load_i     (mode_load),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .restart_i  (restart),
    .tick_i     (tick_i),
    .halt_src_i ({idle_i, dbg_i}),
    .halt_en_i  ({mode_q.idle_hlt, mode_q.dbg_hlt}),
    .cnt_o      (cnt),
    .unf_o      (unf_evt),
    .err_o      (err_evt)
  );

  wdog_fault u_flt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .unf_i      (unf_evt),
    .err_i      (err_evt),
    .clr_i      (stat_clr),
    .flags_o    (flags),
    .irq_o      (irq_o),
    .proc_rst_o (proc_rst_o),
    .sys_rst_o  (sys_rst_o)
  );

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = DATA_W'(mode_q);
      A_STAT:  rdata_o = DATA_W'(flags);
      A_COUNT: rdata_o = DATA_W'(cnt);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk
  import win_wdog_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input mode_t            mode_q,
  input logic [CNT_W-1:0] cnt,
  input logic             unf_evt,
  input logic             err_evt,
  input logic [1:0]       flags,
  input logic             irq_o,
  input logic             proc_rst_o,
  input logic             sys_rst_o
);
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(proc_rst_o && sys_rst_o));

  a_r11_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_rst_o || sys_rst_o) |-> $past(unf_evt || err_evt));

  a_r8_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.dis |-> !(unf_evt || err_evt));

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.dis && $past(mode_q.dis)) |-> $stable(cnt));

  a_r10_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mode_q.fien && (flags != 2'b00)));

  a_r4_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_evt |=> flags[0]);

  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt |=> flags[1]);
endmodule

bind win_wdog win_wdog_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_q     (mode_q),
  .cnt        (cnt),
  .unf_evt    (unf_evt),
  .err_evt    (err_evt),
  .flags      (flags),
  .irq_o      (irq_o),
  .proc_rst_o (proc_rst_o),
  .sys_rst_o  (sys_rst_o)
);

// File: tb/win_wdog_test.sv
module win_wdog_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 0, re_i = 0, tick_i = 0, dbg_i = 0, idle_i = 0;
  logic [1:0]  addr_i = 0;
  logic [31:0] wdata_i = 0;
  logic [31:0] rdata_o;
  logic        irq_o, proc_rst_o, sys_rst_o;

  int tests = 0, fails = 0;

  // reference state
  logic [29:0] m_mode;
  bit          m_wr, m_unf, m_err, m_proc, m_sys;
  logic [11:0] m_cnt;
  logic [31:0] last_rd;

  always #2 clk_i = ~clk_i;  // 250 MHz

  win_wdog uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    case (a)
      2'd1:    return {2'b0, m_mode};
      2'd2:    return {30'b0, m_err, m_unf};
      2'd3:    return {20'b0, m_cnt};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 30'h0FFF2FFF; m_wr = 0; m_cnt = 12'hFFF;
    m_unf = 0; m_err = 0; m_proc = 0; m_sys = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; we_i = 0; re_i = 0; tick_i = 0; addr_i = 0; wdata_i = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic cyc(bit we, bit re, logic [1:0] a, logic [31:0] wd, bit tk, bit dg, bit id);
    bit restart, mwr, halted, run, eu, ee, clr, dis;
    @(negedge clk_i);
    we_i = we; re_i = re; addr_i = a; wdata_i = wd; tick_i = tk; dbg_i = dg; idle_i = id;
    #1;
    last_rd = rdata_o;
    if (a == 2'd1) chk("R2 mode read", rdata_o, exp_rd(a));
    if (a == 2'd2) chk("R9 status read", rdata_o, exp_rd(a));
    if (a == 2'd3) chk("R3 count read", rdata_o, exp_rd(a));
    dis = m_mode[15];
    restart = we && a == 2'd0 && wd[0];
    mwr = we && a == 2'd1 && !m_wr;
    halted = (dg && m_mode[28]) || (id && m_mode[29]);
    run = tk && !halted;
    eu = 0; ee = 0;
    clr = re && a == 2'd2;
    @(posedge clk_i);
    if (mwr) begin
      m_mode = wd[29:0]; m_wr = 1; m_cnt = wd[11:0];
    end else if (!dis) begin
      if (restart && m_cnt <= m_mode[27:16]) m_cnt = m_mode[11:0];
      else begin
        ee = restart;
        if (run) begin
          if (m_cnt == 0) begin eu = 1; m_cnt = m_mode[11:0]; end
          else m_cnt = m_cnt - 1;
        end
      end
    end
    m_proc = (eu || ee) && m_mode[13] && m_mode[14];
    m_sys  = (eu || ee) && m_mode[13] && !m_mode[14];
    // mode is updated above only on mwr, where no fault occurs
    m_unf = eu || (m_unf && !clr);
    m_err = ee || (m_err && !clr);
    #1;
    chk("R10 irq", irq_o, m_mode[12] && (m_unf || m_err));
    chk("R11 proc_rst", proc_rst_o, m_proc);
    chk("R11 sys_rst", sys_rst_o, m_sys);
  endtask

  task automatic peek(logic [1:0] a, logic [31:0] exp, string tag);
    cyc(0, 0, a, 0, 0, 0, 0);
    chk(tag, last_rd, exp);
  endtask

  task automatic tick_n(int n, bit dg = 0, bit id = 0);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 0, 1, dg, id);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    do_reset();
    // R1 defaults
    peek(2'd1, 32'h0FFF2FFF, "R1 mode default");
    peek(2'd3, 32'h00000FFF, "R1 count default");
    peek(2'd2, 32'h0, "R1 status default");
    chk("R1 outputs idle", {irq_o, proc_rst_o, sys_rst_o}, 3'b000);

    // R2 first write: load 5, delta 3, fien, rsten, rproc
    cyc(1, 0, 2'd1, 32'h0003_7005, 0, 0, 0);
    peek(2'd3, 32'd5, "R2 count loaded");
    cyc(1, 0, 2'd1, 32'h0009_0009, 0, 0, 0);
    peek(2'd1, 32'h0003_7005, "R2 second write ignored");
    peek(2'd3, 32'd5, "R2 count kept");

    tick_n(2);
    peek(2'd3, 32'd3, "R3 decrement");
    cyc(1, 0, 2'd0, 32'h1, 0, 0, 0);  // count 3 == delta
    peek(2'd3, 32'd5, "R5 restart at boundary");
    cyc(1, 0, 2'd0, 32'h1, 1, 0, 0);  // count 5 > delta, tick applies
    chk("R11 proc pulse on error", proc_rst_o, 1'b1);
    peek(2'd3, 32'd4, "R6 no reload on early restart");
    chk("R11 single pulse", proc_rst_o, 1'b0);
    peek(2'd2, 32'h2, "R6 error flag");
    chk("R10 irq with flag", irq_o, 1'b1);
    cyc(0, 1, 2'd2, 0, 0, 0, 0);
    peek(2'd2, 32'h0, "R9 cleared by read");
    chk("R10 irq dropped", irq_o, 1'b0);
    tick_n(5, 1, 1);  // halts not enabled
    peek(2'd2, 32'h1, "R4 underflow flag");
    peek(2'd3, 32'd5, "R4 reload after underflow");
    cyc(1, 0, 2'd0, 32'h2, 1, 0, 0);  // bit0 clear: no restart
    peek(2'd3, 32'd4, "R5 only bit0 restarts");

    // halt epoch, full-reset routing, no irq
    do_reset();
    cyc(1, 0, 2'd1, 32'h3002_2004, 0, 0, 0);
    tick_n(3, 1, 0);
    peek(2'd3, 32'd4, "R7 debug halt");
    tick_n(3, 0, 1);
    peek(2'd3, 32'd4, "R7 idle halt");
    tick_n(5);
    chk("R11 sys pulse on underflow", sys_rst_o, 1'b1);
    chk("R10 irq masked", irq_o, 1'b0);
    cyc(0, 1, 2'd2, 0, 1, 0, 0);  // clear while ticking
    tick_n(3);
    cyc(0, 1, 2'd2, 0, 1, 0, 0);  // underflow coincides with clearing read
    peek(2'd2, 32'h1, "R9 set wins over clear");

    // disabled epoch
    do_reset();
    cyc(1, 0, 2'd1, 32'h0000_B000, 0, 0, 0);
    tick_n(4);
    cyc(1, 0, 2'd0, 32'h1, 1, 0, 0);
    peek(2'd3, 32'd0, "R8 disabled count frozen");
    peek(2'd2, 32'h0, "R8 no faults when disabled");

    // random epochs
    for (int e = 0; e < 8; e++) begin
      logic [31:0] cfg;
      do_reset();
      cfg = $urandom & 32'h3000_F000;
      if ($urandom % 5 != 0) cfg[15] = 1'b0;
      cfg[11:0]  = 12'($urandom % 24);
      cfg[27:16] = 12'($urandom % 24);
      cyc(1, 0, 2'd1, cfg, 0, 0, 0);
      for (int i = 0; i < 2500; i++) begin
        int r;
        bit tk, dg, id;
        r = $urandom % 16;
        tk = ($urandom % 4) != 0;
        dg = ($urandom % 5) == 0;
        id = ($urandom % 5) == 0;
        case (r)
          0:       cyc(1, 0, 2'd0, 32'h1, tk, dg, id);
          1:       cyc(0, 1, 2'd2, 0, tk, dg, id);
          2:       cyc(1, 0, 2'd1, $urandom, tk, dg, id);
          3:       cyc(1, 0, 2'd0, $urandom & 32'hFFFF_FFFE, tk, dg, id);
          default: cyc(0, ($urandom % 2) == 0, 2'(r % 4 == 2 ? 3 : r % 4), 0, tk, dg, id);
        endcase
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule